// File: doc/BRIEF.md
# Stream Entry Configuration Evaluator

This block sits right after the fetch of a per-stream configuration entry. It receives one request per cycle. Each request carries the fetched entry and the kind of request being made. The entry fields are a valid flag, a 3-bit configuration field, a 2-bit ATS-mode field and the outcome of an externally computed device-permission check. The block decides what happens next. The request may skip translation altogether, go on to a stage-1 walk, go straight to stage-2 only, or be finished here with a response and, where one applies, an event code.

Three request kinds are accepted: an ordinary memory transaction, an ATS translation request, and an ATS translated transaction. Before the outcome for each kind is chosen, the ATS-mode field is reduced to an effective mode. Encodings that are reserved or inconsistent with the rest of the entry are lowered to "ATS disabled". The decision is registered, so it appears one cycle after the request as a single-cycle result.

Top module: `stream_cfg_eval`

## Requirements
- R1: While reset is held, and at its release, `outValid` is 0 and `outStep`, `outResp`, `outEvent` and `outEffAts` are all zero. They stay zero in every cycle in which `outValid` is 0.
- R2: A request sampled with `reqValid`=1 produces `outValid`=1 for exactly the next cycle. In that cycle `outStep` has exactly one bit set: bit0 bypass, bit1 stage-1 path, bit2 stage-2-only path, bit3 final outcome.
- R3: An entry is illegal when any of the following holds: `entValid`=0; `entCfg` is 001, 010 or 011; or the raw ATS field is 10 (with split mode supported) and `entCfg` is not 111. An illegal entry gives step final and event 1 (bad entry). The response is abort (1) for ordinary transactions and Completer Abort (3) for both ATS kinds.
- R4: `entCfg`=000 on a legal entry ends the request silently with event 0. The response is abort (1) for ordinary and translated transactions and Unsupported Request (2) for translation requests.
- R5: `entCfg`=100 is full bypass. An ordinary transaction gets step bypass, response pass (0) and event 0. A translation request is final with response 2 and event 2 (bad ATS request). A translated transaction is final with response 1 and event 3 (translation forbidden).
- R6: The effective ATS mode `outEffAts` is 00 in each of these cases: `entCfg`=100; the raw field is 10 while `atsCheck`=0; the raw field is 10 and split mode is configured as unsupported. Otherwise it equals the raw field.
- R7: On a translating entry (`entCfg` 101, 110, 111) with effective mode 00, a translation request is final with response 2 and event 2.
- R8: On a translating entry with effective mode 00, a translated transaction is final with response 1 and event 3.
- R9: On a translating entry, a translated transaction with effective mode 11 and `dptOk`=0 is final with response 1 and event 3. With mode 11 and `dptOk`=1, or with mode 01, it gets step bypass, response 0 and event 0.
- R10: On a translating entry, ordinary transactions and translation requests with a usable mode go to stage-1 when `entCfg` is 101 or 111 and to stage-2-only when it is 110. A translated transaction with effective mode 10 goes to stage-2-only. All of these carry response 0 and event 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | 0 ordinary, 1 translation request, 2 translated transaction, 3 handled as ordinary |
| entValid | input | 1 | Entry valid flag |
| entCfg | input | 3 | Entry configuration field |
| entAts | input | 2 | Raw ATS-mode field |
| atsCheck | input | 1 | Global ATS-check enable |
| dptOk | input | 1 | Device-permission check passed |
| outValid | output | 1 | Result present (one cycle) |
| outStep | output | 4 | One-hot next step |
| outResp | output | 2 | 0 pass, 1 abort, 2 Unsupported Request, 3 Completer Abort |
| outEvent | output | 2 | 0 none, 1 bad entry, 2 bad ATS request, 3 translation forbidden |
| outEffAts | output | 2 | Effective ATS mode |

## Verification
The bench targets the precedence between illegal-entry detection and the configuration-specific outcomes. One example is raw mode 10 on a bypass entry: a design that demoted the mode before the legality test would report a bypass outcome instead of a bad entry. The split mode with `atsCheck` low must demote to disabled. If it did not, translation requests would be sent to stage-1 rather than denied. Translated transactions under mode 11 are run with both values of the permission check; a design that ignored the check would pass forbidden traffic. The silent drop at configuration 000 is checked for an event of zero, which catches designs that record a bad-entry event there.

// File: rtl/se_cfg_pkg.sv
package se_cfg_pkg;
  localparam int CfgW   = 3;
  localparam int AtsW   = 2;
  localparam int StepW  = 4;
  localparam int StepBypass = 0;
  localparam int StepS1     = 1;
  localparam int StepS2     = 2;
  localparam int StepFinal  = 3;

  typedef enum logic [1:0] {KIND_ORD = 2'd0, KIND_XREQ = 2'd1, KIND_XLATED = 2'd2, KIND_RSVD = 2'd3} reqKindT;
  typedef enum logic [1:0] {RESP_PASS = 2'd0, RESP_ABORT = 2'd1, RESP_UR = 2'd2, RESP_CA = 2'd3} respT;
  typedef enum logic [1:0] {EVT_NONE = 2'd0, EVT_BAD_ENTRY = 2'd1, EVT_BAD_ATS = 2'd2, EVT_FORBID = 2'd3} evtT;

  localparam logic [AtsW-1:0] AtsOff   = 2'b00;
  localparam logic [AtsW-1:0] AtsFull  = 2'b01;
  localparam logic [AtsW-1:0] AtsSplit = 2'b10;
  localparam logic [AtsW-1:0] AtsDpt   = 2'b11;

  typedef struct packed {
    logic             load;
    logic [StepW-1:0] step;
    respT             resp;
    evtT              evt;
    logic [AtsW-1:0]  effAts;
  } strobeT;
endpackage

// File: rtl/se_ats_demote.sv
module se_ats_demote
  import se_cfg_pkg::*;
#(
  parameter bit SplitAtsEn = 1'b1
) (
  input  logic [CfgW-1:0] cfg,
  input  logic [AtsW-1:0] rawAts,
  input  logic            atsCheck,
  output logic [AtsW-1:0] effAts,
  output logic            splitClaim
);
  logic isBypassCfg;
  logic demote;

  always_comb begin
    isBypassCfg = (cfg == 3'b100);
    splitClaim  = SplitAtsEn && (rawAts == AtsSplit);
    demote      = isBypassCfg
               || ((rawAts == AtsSplit) && !SplitAtsEn)
               || ((rawAts == AtsSplit) && !atsCheck);
    effAts      = demote ? AtsOff : rawAts;
  end

  always_comb begin
    assert_demote_split_R6: assert (!((rawAts == AtsSplit) && !atsCheck) || effAts == AtsOff)
      else $error("split mode without ATS check not demoted");
  end
endmodule

// File: rtl/se_eval_ctrl.sv
module se_eval_ctrl
  import se_cfg_pkg::*;
#(
  parameter bit SplitAtsEn = 1'b1
) (
  input  logic            reqValid,
  input  logic [1:0]      reqKind,
  input  logic            entValid,
  input  logic [CfgW-1:0] entCfg,
  input  logic [AtsW-1:0] entAts,
  input  logic            atsCheck,
  input  logic            dptOk,
  output strobeT          strb
);
  logic [AtsW-1:0] effAts;
  logic            splitClaim;
  logic            isOrd, isXreq, isXlated;
  logic            illegal;
  logic            cfgRsvd;
  logic            s1Walk;

  se_ats_demote #(.SplitAtsEn(SplitAtsEn)) i_demote (
    .cfg(entCfg), .rawAts(entAts), .atsCheck(atsCheck),
    .effAts(effAts), .splitClaim(splitClaim)
  );

  always_comb begin
    isXreq   = (reqKind == KIND_XREQ);
    isXlated = (reqKind == KIND_XLATED);
    isOrd    = !isXreq && !isXlated;
    cfgRsvd  = (entCfg == 3'b001) || (entCfg == 3'b010) || (entCfg == 3'b011);
    illegal  = !entValid || cfgRsvd || (splitClaim && entCfg != 3'b111);
    s1Walk   = entCfg[0];
  end

  task automatic finish(input respT r, input evtT e);
    strb.step = '0;
    strb.step[StepFinal] = 1'b1;
    strb.resp = r;
    strb.evt  = e;
  endtask

  task automatic proceed(input int idx);
    strb.step = '0;
    strb.step[idx] = 1'b1;
    strb.resp = RESP_PASS;
    strb.evt  = EVT_NONE;
  endtask

  always_comb begin
    strb.load   = reqValid;
    strb.effAts = effAts;
    strb.step   = '0;
    strb.resp   = RESP_PASS;
    strb.evt    = EVT_NONE;
    if (illegal) begin
      finish(isOrd ? RESP_ABORT : RESP_CA, EVT_BAD_ENTRY);
    end else if (entCfg == 3'b000) begin
      finish(isXreq ? RESP_UR : RESP_ABORT, EVT_NONE);
    end else if (entCfg == 3'b100) begin
      if (isOrd)       proceed(StepBypass);
      else if (isXreq) finish(RESP_UR, EVT_BAD_ATS);
      else             finish(RESP_ABORT, EVT_FORBID);
    end else if (isXreq) begin
      if (effAts == AtsOff) finish(RESP_UR, EVT_BAD_ATS);
      else                  proceed(s1Walk ? StepS1 : StepS2);
    end else if (isXlated) begin
      if (effAts == AtsOff)                 finish(RESP_ABORT, EVT_FORBID);
      else if (effAts == AtsDpt && !dptOk)  finish(RESP_ABORT, EVT_FORBID);
      else if (effAts == AtsSplit)          proceed(StepS2);
      else                                  proceed(StepBypass);
    end else begin
      proceed(s1Walk ? StepS1 : StepS2);
    end
  end

  always_comb begin
    assert_bad_entry_final_R3: assert (!illegal || (strb.step[StepFinal] && strb.evt == EVT_BAD_ENTRY))
      else $error("illegal entry not finalised as bad entry");
    assert_xlated_no_s1_R10: assert (!isXlated || !strb.step[StepS1])
      else $error("translated transaction routed to stage-1");
  end
endmodule

// File: rtl/se_eval_dp.sv
module se_eval_dp
  import se_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  strobeT           strb,
  output logic             outValid,
  output logic [StepW-1:0] outStep,
  output logic [1:0]       outResp,
  output logic [1:0]       outEvent,
  output logic [AtsW-1:0]  outEffAts
);
  always_ff @(posedge clk) begin
    if (!rst_n || !strb.load) begin
      outValid  <= 1'b0;
      outStep   <= '0;
      outResp   <= '0;
      outEvent  <= '0;
      outEffAts <= '0;
    end else begin
      outValid  <= 1'b1;
      outStep   <= strb.step;
      outResp   <= strb.resp;
      outEvent  <= strb.evt;
      outEffAts <= strb.effAts;
    end
  end

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> (outStep == '0 && outResp == '0 && outEvent == '0 && outEffAts == '0))
    else $error("outputs not cleared while idle");
  assert_step_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $countones(outStep) == 1)
    else $error("step not one-hot");
  assert_pass_not_final_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outResp == RESP_PASS) |-> (!outStep[StepFinal] && outEvent == EVT_NONE))
    else $error("pass response with final step or event");
endmodule

// File: rtl/stream_cfg_eval.sv
module stream_cfg_eval
  import se_cfg_pkg::*;
#(
  parameter bit SplitAtsEn = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       entValid,
  input  logic [2:0] entCfg,
  input  logic [1:0] entAts,
  input  logic       atsCheck,
  input  logic       dptOk,
  output logic       outValid,
  output logic [3:0] outStep,
  output logic [1:0] outResp,
  output logic [1:0] outEvent,
  output logic [1:0] outEffAts
);
  strobeT strb;

  se_eval_ctrl #(.SplitAtsEn(SplitAtsEn)) i_ctrl (
    .reqValid(reqValid), .reqKind(reqKind), .entValid(entValid),
    .entCfg(entCfg), .entAts(entAts), .atsCheck(atsCheck), .dptOk(dptOk),
    .strb(strb)
  );

  se_eval_dp i_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .outValid(outValid), .outStep(outStep), .outResp(outResp),
    .outEvent(outEvent), .outEffAts(outEffAts)
  );

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(reqValid))
    else $error("result without a request");
endmodule

// File: tb/test_stream_cfg_eval.sv
module test_stream_cfg_eval;
  localparam time ClkPeriod = 10ns;
  localparam int  WatchdogCycles = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = '0;
  logic entValid = 1'b0;
  logic [2:0] entCfg = '0;
  logic [1:0] entAts = '0;
  logic atsCheck = 1'b0;
  logic dptOk = 1'b0;
  logic outValid;
  logic [3:0] outStep;
  logic [1:0] outResp, outEvent, outEffAts;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  stream_cfg_eval i_stream_cfg_eval (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqKind(reqKind),
    .entValid(entValid), .entCfg(entCfg), .entAts(entAts),
    .atsCheck(atsCheck), .dptOk(dptOk), .outValid(outValid),
    .outStep(outStep), .outResp(outResp), .outEvent(outEvent),
    .outEffAts(outEffAts)
  );

  localparam logic [3:0] SBYP = 4'b0001, SS1 = 4'b0010, SS2 = 4'b0100, SFIN = 4'b1000;

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h (valid,step,resp,event,effAts)", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [1:0] k, input logic v, input logic [2:0] c,
                     input logic [1:0] a, input logic chk, input logic dpt,
                     input logic [3:0] eStep, input logic [1:0] eResp,
                     input logic [1:0] eEvt, input logic [1:0] eAts);
    @(negedge clk);
    reqKind = k; entValid = v; entCfg = c; entAts = a; atsCheck = chk; dptOk = dpt;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(tag, {outValid, outStep, outResp, outEvent, outEffAts},
               {1'b1, eStep, eResp, eEvt, eAts});
  endtask

  task automatic testReset();
    check("R1 reset", {outValid, outStep, outResp, outEvent, outEffAts}, '0);
  endtask

  task automatic testPulse();
    run("R2 request", 2'd0, 1'b1, 3'b101, 2'b01, 1'b1, 1'b0, SS1, 2'd0, 2'd0, 2'b01);
    @(negedge clk);
    check("R2 single pulse / R1 idle zero", {outValid, outStep, outResp, outEvent, outEffAts}, '0);
  endtask

  task automatic testIllegal();
    run("R3 invalid ord",   2'd0, 1'b0, 3'b101, 2'b01, 1'b1, 1'b1, SFIN, 2'd1, 2'd1, 2'b01);
    run("R3 cfg011 xreq",   2'd1, 1'b1, 3'b011, 2'b01, 1'b1, 1'b1, SFIN, 2'd3, 2'd1, 2'b01);
    run("R3 cfg001 xlated", 2'd2, 1'b1, 3'b001, 2'b00, 1'b1, 1'b1, SFIN, 2'd3, 2'd1, 2'b00);
    run("R3 split on bypass cfg", 2'd0, 1'b1, 3'b100, 2'b10, 1'b1, 1'b1, SFIN, 2'd1, 2'd1, 2'b00);
    run("R3 split on cfg110", 2'd1, 1'b1, 3'b110, 2'b10, 1'b1, 1'b1, SFIN, 2'd3, 2'd1, 2'b10);
  endtask

  task automatic testSilent();
    run("R4 silent ord",    2'd0, 1'b1, 3'b000, 2'b01, 1'b1, 1'b1, SFIN, 2'd1, 2'd0, 2'b01);
    run("R4 silent xreq",   2'd1, 1'b1, 3'b000, 2'b01, 1'b1, 1'b1, SFIN, 2'd2, 2'd0, 2'b01);
    run("R4 silent xlated", 2'd2, 1'b1, 3'b000, 2'b11, 1'b1, 1'b1, SFIN, 2'd1, 2'd0, 2'b11);
  endtask

  task automatic testBypass();
    run("R5 bypass ord",    2'd0, 1'b1, 3'b100, 2'b01, 1'b1, 1'b1, SBYP, 2'd0, 2'd0, 2'b00);
    run("R5 bypass xreq",   2'd1, 1'b1, 3'b100, 2'b01, 1'b1, 1'b1, SFIN, 2'd2, 2'd2, 2'b00);
    run("R5 bypass xlated", 2'd2, 1'b1, 3'b100, 2'b11, 1'b1, 1'b1, SFIN, 2'd1, 2'd3, 2'b00);
    run("R5 kind3 as ord",  2'd3, 1'b1, 3'b100, 2'b00, 1'b1, 1'b1, SBYP, 2'd0, 2'd0, 2'b00);
  endtask

  task automatic testDemote();
    run("R6 R7 split no check xreq", 2'd1, 1'b1, 3'b111, 2'b10, 1'b0, 1'b1, SFIN, 2'd2, 2'd2, 2'b00);
    run("R6 split with check ord",   2'd0, 1'b1, 3'b111, 2'b10, 1'b1, 1'b1, SS1, 2'd0, 2'd0, 2'b10);
    run("R6 R8 split no check xlated", 2'd2, 1'b1, 3'b111, 2'b10, 1'b0, 1'b1, SFIN, 2'd1, 2'd3, 2'b00);
  endtask

  task automatic testAtsOff();
    run("R7 off xreq",   2'd1, 1'b1, 3'b110, 2'b00, 1'b1, 1'b1, SFIN, 2'd2, 2'd2, 2'b00);
    run("R8 off xlated", 2'd2, 1'b1, 3'b101, 2'b00, 1'b1, 1'b1, SFIN, 2'd1, 2'd3, 2'b00);
    run("R10 off ord stage1", 2'd0, 1'b1, 3'b101, 2'b00, 1'b1, 1'b1, SS1, 2'd0, 2'd0, 2'b00);
  endtask

  task automatic testDpt();
    run("R9 dpt fail",   2'd2, 1'b1, 3'b101, 2'b11, 1'b1, 1'b0, SFIN, 2'd1, 2'd3, 2'b11);
    run("R9 dpt pass",   2'd2, 1'b1, 3'b101, 2'b11, 1'b1, 1'b1, SBYP, 2'd0, 2'd0, 2'b11);
    run("R9 full ats ignores dpt", 2'd2, 1'b1, 3'b110, 2'b01, 1'b1, 1'b0, SBYP, 2'd0, 2'd0, 2'b01);
  endtask

  task automatic testRouting();
    run("R10 xreq stage2",   2'd1, 1'b1, 3'b110, 2'b01, 1'b1, 1'b1, SS2, 2'd0, 2'd0, 2'b01);
    run("R10 ord stage2",    2'd0, 1'b1, 3'b110, 2'b11, 1'b1, 1'b1, SS2, 2'd0, 2'd0, 2'b11);
    run("R10 xreq stage1",   2'd1, 1'b1, 3'b111, 2'b01, 1'b1, 1'b1, SS1, 2'd0, 2'd0, 2'b01);
    run("R10 xlated split",  2'd2, 1'b1, 3'b111, 2'b10, 1'b1, 1'b0, SS2, 2'd0, 2'd0, 2'b10);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testPulse();
    testIllegal();
    testSilent();
    testBypass();
    testDemote();
    testAtsOff();
    testDpt();
    testRouting();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (WatchdogCycles) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end
endmodule